// File: doc/BRIEF.md
# Banked Frame Buffer with Lane Routing

This block is a dual-ported row memory that feeds eight 16-bit processing lanes. Each row is 128 bits wide, made of eight 2-byte banks. A system-side port moves whole rows in and out for bulk transfer. An array-side port reads the stored data and passes it through a routing stage to the lanes. The routing stage has three settings. It can send one byte to all lanes, send one 16-bit word to all lanes, or spread a 16-byte window across the lanes so that each lane gets its own word.

The window can start at any byte of a row. When it starts past byte 0, the rest of the window comes from the next row. To read both rows in the same cycle, the storage is split into an even-row half and an odd-row half. Every array request takes one clock. A valid strobe marks the cycle in which the lane outputs carry the result of a request.

Top module: `lane_route_buffer`

## Requirements
- R1: After a synchronous active-low reset, `lane_valid` is 0 and both `lane_data` and `sys_rdata` are all zeros.
- R2: With `sys_en`=1 and `sys_we`=1, the full 128-bit `sys_wdata` is stored at row `sys_addr`. A system read (`sys_en`=1, `sys_we`=0) presents that row on `sys_rdata` one clock later. Byte k of a row is bits 8k+7:8k.
- R3: A request on `arr_req` sampled at a clock edge raises `lane_valid` for exactly the following cycle. Without a request, `lane_valid` is 0 and `lane_data` holds its previous value.
- R4: In spread mode (`arr_mode`=2'b00) with `arr_offset`=0, lane i (bits 16i+15:16i of `lane_data`) receives byte 2i of row `arr_row` in bits 7:0 and byte 2i+1 in bits 15:8.
- R5: In spread mode with a nonzero offset o, the window is bytes o..15 of row n followed by bytes 0..o-1 of row n+1. Lane i receives window byte 2i as its low byte and window byte 2i+1 as its high byte.
- R6: When the requested row is the last row (DEPTH-1), the tail of a spread window is taken from row 0.
- R7: In byte-broadcast mode (`arr_mode`=2'b01), every lane receives byte `arr_offset` of row n, zero-extended to 16 bits.
- R8: In word-broadcast mode (`arr_mode`=2'b10), every lane receives bank `arr_offset[2:0]` of row n, that is bytes 2b and 2b+1 with the lower address in bits 7:0. `arr_offset[3]` has no effect.
- R9: The reserved mode 2'b11 drives all lanes to zero, and `lane_valid` still follows R3.
- R10: When a system write and an array request address the same row in the same cycle, the array side returns the data held before the write, and the write still takes effect for later reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sys_en | input | 1 | System port access enable |
| sys_we | input | 1 | System port write (1) or read (0) |
| sys_addr | input | 12 | System port row address |
| sys_wdata | input | 128 | Row to write |
| sys_rdata | output | 128 | Row read, one clock after request |
| arr_req | input | 1 | Array-side read request |
| arr_row | input | 12 | Array-side row n |
| arr_mode | input | 2 | 00 spread, 01 byte broadcast, 10 word broadcast, 11 reserved |
| arr_offset | input | 4 | Byte offset for window start or broadcast byte; bits 2:0 pick the word bank |
| lane_valid | output | 1 | Lane outputs carry a fresh result |
| lane_data | output | 128 | Eight 16-bit lane values, lane i at bits 16i+15:16i |

## Verification
Most of the stimulus is random requests over a set of filled rows, covering every mode and offset, mixed with random system writes. Offset 0 and offsets from 1 to 15 are tried with both even and odd starting rows. This separates the aligned path from the two-row window and shows whether each parity half is used as the current row or the next row. Directed cases cover the wrap from the last row to row 0, both values of the unused offset bit in word mode, and a same-cycle write to the row being read, which tells old-data return apart from write-through. Idle cycles after a request show that lane outputs are held and the strobe drops.

// File: rtl/lrb_pkg.sv
// Shared mode encoding for the lane routing buffer.
package lrb_pkg;
    typedef enum logic [1:0] {
        MODE_SPREAD = 2'b00,
        MODE_BYTE   = 2'b01,
        MODE_WORD   = 2'b10,
        MODE_NONE   = 2'b11
    } lane_mode_e;
endpackage

// File: rtl/lrb_bank_half.sv
// One parity half of the row storage (all even rows or all odd rows).
// Has a registered read port for the array side, and a read/write port
// for the system side. A read during a write to the same row returns old data.
// Assumes: the storage contents are not reset; the read registers are.
module lrb_bank_half #(
    parameter int ROW_W = 128,
    parameter int ROWS  = 1280,
    localparam int IW   = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [IW-1:0]    rd_idx,
    output logic [ROW_W-1:0] rd_row,
    input  logic             sys_en,
    input  logic             sys_we,
    input  logic [IW-1:0]    sys_idx,
    input  logic [ROW_W-1:0] sys_wdata,
    output logic [ROW_W-1:0] sys_rdata
);
    logic [ROW_W-1:0] mem [ROWS];

    // Store a row from the system side
    always_ff @(posedge clk) begin
        if (sys_en && sys_we) mem[sys_idx] <= sys_wdata;
    end

    // Capture the row requested by the array side
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_row <= '0;
        else if (rd_en) rd_row <= mem[rd_idx];
    end

    // Capture the row requested by a system read
    always_ff @(posedge clk) begin
        if (!rst_n)                  sys_rdata <= '0;
        else if (sys_en && !sys_we)  sys_rdata <= mem[sys_idx];
    end
endmodule

// File: rtl/lrb_lane_router.sv
// Combinational routing from two consecutive rows to the lanes.
// Spread mode rotates a byte window that starts at offset in cur_row and
// continues into nxt_row. The broadcast modes copy one byte or one bank to
// every lane. Assumes: rows are little-endian bytes, byte k at bits 8k+7:8k.
module lrb_lane_router
    import lrb_pkg::*;
#(
    parameter int LANES = 8,
    localparam int RB    = 2 * LANES,
    localparam int OW    = $clog2(RB),
    localparam int ROW_W = 16 * LANES
) (
    input  logic [ROW_W-1:0] cur_row,
    input  logic [ROW_W-1:0] nxt_row,
    input  lane_mode_e       mode,
    input  logic [OW-1:0]    offset,
    output logic [ROW_W-1:0] lanes
);
    logic [2*ROW_W-1:0] pair;
    logic [7:0]         sel_byte;
    logic [15:0]        sel_word;

    // Join both rows and pick the broadcast sources
    always_comb begin
        pair     = {nxt_row, cur_row};
        sel_byte = cur_row[8*offset +: 8];
        sel_word = cur_row[16*offset[OW-2:0] +: 16];
    end

    // Drive each lane according to the mode
    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            always_comb begin
                case (mode)
                    MODE_SPREAD: lanes[16*i +: 16] =
                        {pair[8*(int'(offset) + 2*i + 1) +: 8],
                         pair[8*(int'(offset) + 2*i) +: 8]};
                    MODE_BYTE:   lanes[16*i +: 16] = {8'h00, sel_byte};
                    MODE_WORD:   lanes[16*i +: 16] = sel_word;
                    default:     lanes[16*i +: 16] = 16'h0000;
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/lane_route_buffer.sv
// Top of the banked frame buffer with lane routing. Even rows sit in one
// half and odd rows in the other, so row n and row n+1 are read in the same
// cycle. The last row's successor is row 0. Array reads have one clock of
// latency and are qualified by lane_valid.
// Assumes: DEPTH is even and at least 2.
module lane_route_buffer
    import lrb_pkg::*;
#(
    parameter int DEPTH = 2560,
    parameter int LANES = 8,
    localparam int ROW_W = 16 * LANES,
    localparam int RB    = 2 * LANES,
    localparam int OW    = $clog2(RB),
    localparam int AW    = $clog2(DEPTH),
    localparam int HALF  = DEPTH / 2,
    localparam int IW    = AW - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sys_en,
    input  logic             sys_we,
    input  logic [AW-1:0]    sys_addr,
    input  logic [ROW_W-1:0] sys_wdata,
    output logic [ROW_W-1:0] sys_rdata,
    input  logic             arr_req,
    input  logic [AW-1:0]    arr_row,
    input  logic [1:0]       arr_mode,
    input  logic [OW-1:0]    arr_offset,
    output logic             lane_valid,
    output logic [ROW_W-1:0] lane_data
);
    logic [AW-1:0]    next_row;
    logic [ROW_W-1:0] half_rd   [2];
    logic [ROW_W-1:0] half_sys  [2];
    logic             par_q;
    logic             sys_par_q;
    lane_mode_e       mode_q;
    logic [OW-1:0]    off_q;
    logic             valid_q;
    logic [ROW_W-1:0] cur_row;
    logic [ROW_W-1:0] nxt_row;

    // Successor row, wrapping at the end of the memory
    always_comb begin
        if (arr_row == AW'(DEPTH - 1)) next_row = '0;
        else                           next_row = arr_row + 1'b1;
    end

    // One storage half per row parity
    generate
        for (genvar p = 0; p < 2; p++) begin : g_half
            logic [AW-1:0] pick_row;
            // Row held by this half: the requested row or its successor
            always_comb begin
                pick_row = (arr_row[0] == 1'(p)) ? arr_row : next_row;
            end
            lrb_bank_half #(.ROW_W(ROW_W), .ROWS(HALF)) u_half (
                .clk       (clk),
                .rst_n     (rst_n),
                .rd_en     (arr_req),
                .rd_idx    (pick_row[AW-1:1]),
                .rd_row    (half_rd[p]),
                .sys_en    (sys_en && (sys_addr[0] == 1'(p))),
                .sys_we    (sys_we),
                .sys_idx   (sys_addr[AW-1:1]),
                .sys_wdata (sys_wdata),
                .sys_rdata (half_sys[p])
            );
        end
    endgenerate

    // Register the request controls next to the row data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_q   <= 1'b0;
            mode_q  <= MODE_SPREAD;
            off_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= arr_req;
            if (arr_req) begin
                par_q  <= arr_row[0];
                mode_q <= lane_mode_e'(arr_mode);
                off_q  <= arr_offset;
            end
        end
    end

    // Remember which half answers the system read
    always_ff @(posedge clk) begin
        if (!rst_n)                 sys_par_q <= 1'b0;
        else if (sys_en && !sys_we) sys_par_q <= sys_addr[0];
    end

    // Order the two halves as current and next row
    always_comb begin
        cur_row = par_q ? half_rd[1] : half_rd[0];
        nxt_row = par_q ? half_rd[0] : half_rd[1];
    end

    lrb_lane_router #(.LANES(LANES)) u_router (
        .cur_row (cur_row),
        .nxt_row (nxt_row),
        .mode    (mode_q),
        .offset  (off_q),
        .lanes   (lane_data)
    );

    assign lane_valid = valid_q;
    assign sys_rdata  = half_sys[sys_par_q];
endmodule

// File: rtl/lrb_checker.sv
// Timing and shape properties of the lane outputs, bound to the top.
module lrb_checker #(
    parameter int LANES = 8,
    localparam int ROW_W = 16 * LANES
) (
    input logic             clk,
    input logic             rst_n,
    input logic             arr_req,
    input logic [1:0]       arr_mode,
    input logic             lane_valid,
    input logic [ROW_W-1:0] lane_data
);
    logic uniform;
    logic upper_zero;

    // Shape of the lane outputs seen from outside
    always_comb begin
        uniform    = (lane_data == {LANES{lane_data[15:0]}});
        upper_zero = 1'b1;
        for (int i = 0; i < LANES; i++)
            if (lane_data[16*i+8 +: 8] != 8'h00) upper_zero = 1'b0;
    end

    AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        arr_req |=> lane_valid);                                   // R3
    AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !arr_req |=> !lane_valid);                                 // R3
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !arr_req |=> $stable(lane_data));                          // R3
    AST_BYTE_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_req && arr_mode == 2'b01) |=> (uniform && upper_zero)); // R7
    AST_WORD_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_req && arr_mode == 2'b10) |=> uniform);               // R8
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_req && arr_mode == 2'b11) |=> (lane_data == '0));     // R9
endmodule

bind lane_route_buffer lrb_checker #(.LANES(LANES)) u_lrb_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .arr_req    (arr_req),
    .arr_mode   (arr_mode),
    .lane_valid (lane_valid),
    .lane_data  (lane_data)
);

// File: tb/lane_route_buffer_bench.sv
`timescale 1ns/1ps
module lane_route_buffer_bench;
    localparam int DEPTH = 2560;
    localparam int AW    = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sys_en = 1'b0, sys_we = 1'b0;
    logic [AW-1:0] sys_addr = '0;
    logic [127:0] sys_wdata = '0;
    logic [127:0] sys_rdata;
    logic         arr_req = 1'b0;
    logic [AW-1:0] arr_row = '0;
    logic [1:0]   arr_mode = 2'b00;
    logic [3:0]   arr_offset = '0;
    logic         lane_valid;
    logic [127:0] lane_data;

    logic [127:0] model [DEPTH];
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lane_route_buffer u_lane_route_buffer (
        .clk(clk), .rst_n(rst_n),
        .sys_en(sys_en), .sys_we(sys_we), .sys_addr(sys_addr),
        .sys_wdata(sys_wdata), .sys_rdata(sys_rdata),
        .arr_req(arr_req), .arr_row(arr_row), .arr_mode(arr_mode),
        .arr_offset(arr_offset), .lane_valid(lane_valid), .lane_data(lane_data)
    );

    function automatic logic [127:0] rand_row();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    // Expected lanes from the requirement text
    function automatic logic [127:0] expect_lanes(int row, int mode, int off);
        logic [255:0] both;
        logic [127:0] res;
        int nx;
        nx   = (row == DEPTH - 1) ? 0 : row + 1;
        both = {model[nx], model[row]};
        res  = '0;
        for (int i = 0; i < 8; i++) begin
            case (mode)
                0: res[16*i +: 16] = {both[8*(off+2*i+1) +: 8], both[8*(off+2*i) +: 8]};
                1: res[16*i +: 16] = {8'h00, both[8*off +: 8]};
                2: res[16*i +: 16] = {both[8*(2*(off%8)+1) +: 8], both[8*(2*(off%8)) +: 8]};
                default: res[16*i +: 16] = 16'h0000;
            endcase
        end
        return res;
    endfunction

    task automatic check(string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic sys_write(int row, logic [127:0] d);
        @(negedge clk);
        sys_en = 1'b1; sys_we = 1'b1; sys_addr = AW'(row); sys_wdata = d;
        @(negedge clk);
        sys_en = 1'b0; sys_we = 1'b0;
        model[row] = d;
    endtask

    task automatic sys_read_check(int row);
        @(negedge clk);
        sys_en = 1'b1; sys_we = 1'b0; sys_addr = AW'(row);
        @(negedge clk);
        sys_en = 1'b0;
        check("R2 system readback", sys_rdata, model[row]);
    endtask

    // Issue a request, check lanes one clock later
    task automatic arr_read(int row, int mode, int off, string req);
        @(negedge clk);
        arr_req = 1'b1; arr_row = AW'(row); arr_mode = 2'(mode); arr_offset = 4'(off);
        @(negedge clk);
        arr_req = 1'b0;
        check(req, lane_data, expect_lanes(row, mode, off));
        check("R3 valid after request", {127'b0, lane_valid}, 128'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [127:0] held, old_row, new_row;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 lane_valid after reset", {127'b0, lane_valid}, 128'd0);
        check("R1 lane_data after reset", lane_data, '0);
        check("R1 sys_rdata after reset", sys_rdata, '0);
        rst_n = 1'b1;

        for (int r = 0; r < 32; r++) sys_write(r, rand_row());
        sys_write(DEPTH - 2, rand_row());
        sys_write(DEPTH - 1, rand_row());
        sys_read_check(5);
        sys_read_check(6);
        sys_read_check(DEPTH - 1);

        // R4 aligned spread, even and odd rows
        arr_read(4, 0, 0, "R4 aligned spread even row");
        arr_read(7, 0, 0, "R4 aligned spread odd row");
        // R5 unaligned windows
        arr_read(2, 0, 5, "R5 offset 5 even row");
        arr_read(9, 0, 15, "R5 offset 15 odd row");
        // R3 hold and strobe drop
        held = lane_data;
        @(negedge clk);
        check("R3 valid low when idle", {127'b0, lane_valid}, 128'd0);
        check("R3 lanes held when idle", lane_data, held);
        // R6 wrap to row 0
        arr_read(DEPTH - 1, 0, 3, "R6 last row wraps to row 0");
        arr_read(DEPTH - 1, 0, 0, "R6 last row aligned");
        // R7 byte broadcast
        arr_read(10, 1, 15, "R7 byte broadcast top byte");
        arr_read(11, 1, 0, "R7 byte broadcast byte 0");
        // R8 word broadcast, offset bit 3 no effect
        arr_read(12, 2, 3, "R8 word broadcast bank 3");
        held = lane_data;
        arr_read(12, 2, 11, "R8 offset bit 3 ignored");
        check("R8 same word with offset bit 3 set", lane_data, held);
        // R9 reserved mode
        arr_read(13, 3, 7, "R9 reserved mode zero");

        // R10 same-row collision
        old_row = model[20];
        new_row = rand_row();
        @(negedge clk);
        arr_req = 1'b1; arr_row = AW'(20); arr_mode = 2'b00; arr_offset = 4'd0;
        sys_en = 1'b1; sys_we = 1'b1; sys_addr = AW'(20); sys_wdata = new_row;
        @(negedge clk);
        arr_req = 1'b0; sys_en = 1'b0; sys_we = 1'b0;
        check("R10 collision returns old data", lane_data, old_row);
        model[20] = new_row;
        arr_read(20, 0, 0, "R10 write landed");

        // Random mix of reads and writes
        for (int k = 0; k < 400; k++) begin
            int row;
            row = (k % 3 == 0) ? int'($urandom_range(31, 0)) : int'($urandom_range(30, 0));
            if ($urandom_range(4, 0) == 0) sys_write(row, rand_row());
            else arr_read(row, int'($urandom_range(3, 0)), int'($urandom_range(15, 0)),
                          "R4 R5 R7 R8 R9 random read");
        end
        arr_read(DEPTH - 2, 0, 9, "R5 window into last row");
        finish_run();
    end
endmodule